// File: doc/BRIEF.md
# System Control Register File

This block holds the privileged control registers of a processor core: the operating-mode word (index 0), the faulting-address register (index 2), the translation-table base (index 3), the extension-enable word (index 4) and the task-priority threshold (index 8). The core's decoder presents move-to and move-from requests to it. Each request carries a register index, write data, the current privilege level and the current execution mode. The block checks every request against its access rules. A request that passes updates the register or returns its value. A request that fails produces a fault with a cause code and changes no register.

The block also drives the decoded operating flags (protection, paging, write protect, cache disable, task switched) and the priority threshold to the rest of the core. A task-switch strobe from the core sets the task-switched flag. A strobe that marks the issue of a floating-point or vector instruction raises a device-not-available fault while that flag is set. All results are registered and appear one cycle after the request.

Top module: `sysctl_regfile`

## Requirements
- R1: After reset, index 0 reads 0x10 (only bit 4 set), indices 2, 3, 4 and 8 read zero, every output flag is low and no response or fault pulse is given.
- R2: A request is answered exactly one cycle later, either by a one-cycle `rsp_valid` pulse or by a one-cycle `fault_valid` pulse, never both. The cause codes are 0 none, 1 general protection (GP), 2 undefined register (UD) and 3 device not available (NM). A read returns its value on `rsp_rdata`, and a write returns zero there.
- R3: Only indices 0, 2, 3, 4 and 8 exist. Index 1 and every other index fault with UD.
- R4: In modes other than real (mode codes: 0 real, 1 protected, 2 compatibility, 3 64-bit), any access with a privilege level other than 0 faults with GP. In real mode the privilege level is ignored. UD takes priority over GP.
- R5: Outside 64-bit mode, bits 63:32 of write data are ignored, and reads return only bits 31:0, zero-extended.
- R6: In 64-bit mode, a write to index 0 or 4 with any of bits 63:32 set faults with GP.
- R7: A write to index 0 with bit 31 (paging) set and bit 0 (protection) clear faults with GP.
- R8: Index 0 keeps bits 0, 3, 5, 16, 18, 29, 30 and 31. Bit 4 always reads 1, and every other bit reads 0.
- R9: Index 2 keeps all 64 bits with no address-width check.
- R10: A write to index 3 with any of bits 51:40 set faults with GP. Otherwise bits 63:52 and 39:12 are kept without any width check, bit 3 and bit 4 are kept as the two cache-policy flags, and all other bits read 0.
- R11: Index 8 exists only in 64-bit mode and faults with UD in any other mode. It keeps bits 3:0, which drive `tpr`.
- R12: A faulting request leaves every register unchanged.
- R13: A `task_switch` strobe sets bit 3 of index 0 by the next cycle. An `fp_issue` strobe with that bit set and no request in the same cycle gives an NM fault.
- R14: `prot_en`, `paging_en`, `wr_protect`, `cache_dis` and `task_sw` follow bits 0, 31, 16, 30 and 3 of index 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 for move-to, 0 for move-from |
| req_idx | input | 4 | Register index |
| req_wdata | input | 64 | Write data |
| req_cpl | input | 2 | Current privilege level |
| req_mode | input | 2 | Execution mode: 0 real, 1 protected, 2 compatibility, 3 64-bit |
| task_switch | input | 1 | Task-switch strobe |
| fp_issue | input | 1 | Floating-point or vector instruction issue strobe |
| rsp_valid | output | 1 | Successful-request pulse |
| rsp_rdata | output | 64 | Read data |
| fault_valid | output | 1 | Fault pulse |
| fault_cause | output | 2 | Fault cause code |
| prot_en | output | 1 | Protection enabled |
| paging_en | output | 1 | Paging enabled |
| wr_protect | output | 1 | Supervisor write protect |
| cache_dis | output | 1 | Cache disable |
| task_sw | output | 1 | Task-switched flag |
| tpr | output | 4 | Task-priority threshold |

## Verification
The assertions assume that the mode and privilege inputs are only sampled while `req_valid` is high, and that a floating-point strobe checked for NM arrives with no request in the same cycle. The bench drives every request for exactly one cycle. It holds the control inputs steady between requests, issues `fp_issue` only on idle cycles, and raises `task_switch` alone. A scoreboard queue therefore lines up one expected response or fault with each pulse the block produces.

// File: rtl/sysctl_pkg.sv
// Package: shared widths, masks, mode and fault-cause encodings for the
// system control register file. Assumes a 64-bit machine word.
package sysctl_pkg;
    parameter int XLEN  = 64;
    parameter int IDX_W = 4;
    parameter int TPR_W = 4;
    parameter int HALF  = XLEN / 2;

    typedef enum logic [1:0] {
        MODE_REAL   = 2'd0,
        MODE_PROT   = 2'd1,
        MODE_COMPAT = 2'd2,
        MODE_LONG   = 2'd3
    } exec_mode_e;

    typedef enum logic [1:0] {
        FLT_NONE = 2'd0,
        FLT_GP   = 2'd1,
        FLT_UD   = 2'd2,
        FLT_NM   = 2'd3
    } fault_e;

    localparam logic [IDX_W-1:0] IDX_OPMODE = 4'd0;
    localparam logic [IDX_W-1:0] IDX_FADDR  = 4'd2;
    localparam logic [IDX_W-1:0] IDX_TBASE  = 4'd3;
    localparam logic [IDX_W-1:0] IDX_EXTEN  = 4'd4;
    localparam logic [IDX_W-1:0] IDX_PRIO   = 4'd8;

    // Bits kept in the operating-mode word (PE, TS, NE, WP, AM, NW, CD, PG).
    localparam logic [XLEN-1:0] OPMODE_KEEP = 64'h0000_0000_E005_0029;
    localparam logic [XLEN-1:0] OPMODE_ET   = 64'h0000_0000_0000_0010;
    // Table base keeps 63:52, 39:12 and the two cache-policy flags.
    localparam logic [XLEN-1:0] TBASE_KEEP  = 64'hFFF0_00FF_FFFF_F018;
    localparam logic [XLEN-1:0] TBASE_RSVD  = 64'h000F_FF00_0000_0000;
    localparam logic [XLEN-1:0] EXTEN_KEEP  = 64'h0000_0000_FFFF_FFFF;
    localparam logic [XLEN-1:0] PRIO_KEEP   = XLEN'((1 << TPR_W) - 1);
endpackage

// File: rtl/sysctl_access_check.sv
// Access checker: purely combinational. Decides for the current request
// whether it is legal and which register it may write. Assumes the inputs
// are stable for the cycle in which req_valid is high.
module sysctl_access_check
    import sysctl_pkg::*;
(
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [IDX_W-1:0] req_idx,
    input  logic [XLEN-1:0]  req_wdata,
    input  logic [1:0]       req_cpl,
    input  exec_mode_e       req_mode,
    input  logic             fp_issue,
    input  logic             ts_flag,
    output fault_e           cause,
    output logic             req_ok,
    output logic [XLEN-1:0]  eff_wdata,
    output logic [4:0]       wr_sel
);
    logic is_long;
    logic idx_known;
    logic upper_nz;

    // Narrow the write data to the width of the current mode.
    always_comb begin
        is_long   = (req_mode == MODE_LONG);
        eff_wdata = is_long ? req_wdata : {{HALF{1'b0}}, req_wdata[HALF-1:0]};
        upper_nz  = |eff_wdata[XLEN-1:HALF];
        idx_known = (req_idx == IDX_OPMODE) || (req_idx == IDX_FADDR) ||
                    (req_idx == IDX_TBASE)  || (req_idx == IDX_EXTEN) ||
                    (req_idx == IDX_PRIO);
    end

    // Rule evaluation in priority order: UD, privilege GP, value GP, NM.
    always_comb begin
        cause = FLT_NONE;
        if (!req_valid) begin
            if (fp_issue && ts_flag) cause = FLT_NM;
        end else if (!idx_known || (req_idx == IDX_PRIO && !is_long)) begin
            cause = FLT_UD;
        end else if (req_mode != MODE_REAL && req_cpl != 2'd0) begin
            cause = FLT_GP;
        end else if (req_write) begin
            if (req_idx == IDX_OPMODE &&
                (upper_nz || (eff_wdata[31] && !eff_wdata[0])))
                cause = FLT_GP;
            else if (req_idx == IDX_EXTEN && upper_nz)
                cause = FLT_GP;
            else if (req_idx == IDX_TBASE && |(eff_wdata & TBASE_RSVD))
                cause = FLT_GP;
        end
    end

    // Legal request flag and one-hot write enables {prio, exten, tbase, faddr, opmode}.
    always_comb begin
        req_ok = req_valid && (cause == FLT_NONE);
        wr_sel = '0;
        if (req_ok && req_write) begin
            wr_sel[0] = (req_idx == IDX_OPMODE);
            wr_sel[1] = (req_idx == IDX_FADDR);
            wr_sel[2] = (req_idx == IDX_TBASE);
            wr_sel[3] = (req_idx == IDX_EXTEN);
            wr_sel[4] = (req_idx == IDX_PRIO);
        end
    end
endmodule

// File: rtl/sysctl_reg_store.sv
// Register storage: holds the five registers, applies the keep masks on
// write and sets the task-switched flag on a task-switch strobe. Assumes
// wr_sel is one-hot or zero and data is already width-narrowed.
module sysctl_reg_store
    import sysctl_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [4:0]      wr_sel,
    input  logic [XLEN-1:0] wdata,
    input  logic            task_switch,
    output logic [XLEN-1:0] opmode_q,
    output logic [XLEN-1:0] faddr_q,
    output logic [XLEN-1:0] tbase_q,
    output logic [XLEN-1:0] exten_q,
    output logic [XLEN-1:0] prio_q
);
    logic [XLEN-1:0] keep_mask [5];
    logic [XLEN-1:0] regs_q    [5];

    assign keep_mask[0] = OPMODE_KEEP;
    assign keep_mask[1] = '1;
    assign keep_mask[2] = TBASE_KEEP;
    assign keep_mask[3] = EXTEN_KEEP;
    assign keep_mask[4] = PRIO_KEEP;

    for (genvar g = 1; g < 5; g++) begin : g_plain
        // Masked load of one plain register.
        always_ff @(posedge clk) begin
            if (!rst_n)         regs_q[g] <= '0;
            else if (wr_sel[g]) regs_q[g] <= wdata & keep_mask[g];
        end
    end

    // Operating-mode word: masked load, task switch ORs in bit 3.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q[0] <= '0;
        end else begin
            if (wr_sel[0]) regs_q[0] <= (wdata & keep_mask[0]) | {{(XLEN-4){1'b0}}, task_switch, 3'b000};
            else if (task_switch) regs_q[0][3] <= 1'b1;
        end
    end

    assign opmode_q = regs_q[0] | OPMODE_ET;
    assign faddr_q  = regs_q[1];
    assign tbase_q  = regs_q[2];
    assign exten_q  = regs_q[3];
    assign prio_q   = regs_q[4];
endmodule

// File: rtl/sysctl_regfile.sv
// Top: system control register file. Checks each move-to/move-from
// request, updates storage or returns data, and reports faults one cycle
// later. Assumes one request per cycle at most and a core that holds the
// mode and privilege steady for the request cycle.
module sysctl_regfile
    import sysctl_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic        req_write,
    input  logic [3:0]  req_idx,
    input  logic [63:0] req_wdata,
    input  logic [1:0]  req_cpl,
    input  logic [1:0]  req_mode,
    input  logic        task_switch,
    input  logic        fp_issue,
    output logic        rsp_valid,
    output logic [63:0] rsp_rdata,
    output logic        fault_valid,
    output logic [1:0]  fault_cause,
    output logic        prot_en,
    output logic        paging_en,
    output logic        wr_protect,
    output logic        cache_dis,
    output logic        task_sw,
    output logic [3:0]  tpr
);
    exec_mode_e      mode_e;
    fault_e          cause;
    logic            req_ok;
    logic [XLEN-1:0] eff_wdata;
    logic [4:0]      wr_sel;
    logic [XLEN-1:0] opmode_q, faddr_q, tbase_q, exten_q, prio_q;
    logic [XLEN-1:0] rd_mux;

    assign mode_e = exec_mode_e'(req_mode);

    sysctl_access_check u_check (
        .req_valid (req_valid),
        .req_write (req_write),
        .req_idx   (req_idx),
        .req_wdata (req_wdata),
        .req_cpl   (req_cpl),
        .req_mode  (mode_e),
        .fp_issue  (fp_issue),
        .ts_flag   (opmode_q[3]),
        .cause     (cause),
        .req_ok    (req_ok),
        .eff_wdata (eff_wdata),
        .wr_sel    (wr_sel)
    );

    sysctl_reg_store u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_sel      (wr_sel),
        .wdata       (eff_wdata),
        .task_switch (task_switch),
        .opmode_q    (opmode_q),
        .faddr_q     (faddr_q),
        .tbase_q     (tbase_q),
        .exten_q     (exten_q),
        .prio_q      (prio_q)
    );

    // Read selection, narrowed to 32 bits outside 64-bit mode.
    always_comb begin
        case (req_idx)
            IDX_OPMODE: rd_mux = opmode_q;
            IDX_FADDR:  rd_mux = faddr_q;
            IDX_TBASE:  rd_mux = tbase_q;
            IDX_EXTEN:  rd_mux = exten_q;
            IDX_PRIO:   rd_mux = prio_q;
            default:    rd_mux = '0;
        endcase
        if (mode_e != MODE_LONG) rd_mux[XLEN-1:HALF] = '0;
    end

    // Registered response and fault pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid   <= 1'b0;
            rsp_rdata   <= '0;
            fault_valid <= 1'b0;
            fault_cause <= FLT_NONE;
        end else begin
            rsp_valid   <= req_ok;
            rsp_rdata   <= (req_ok && !req_write) ? rd_mux : '0;
            fault_valid <= (cause != FLT_NONE);
            fault_cause <= cause;
        end
    end

    assign prot_en    = opmode_q[0];
    assign paging_en  = opmode_q[31];
    assign wr_protect = opmode_q[16];
    assign cache_dis  = opmode_q[30];
    assign task_sw    = opmode_q[3];
    assign tpr        = prio_q[TPR_W-1:0];

    assert_rsp_fault_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_valid && fault_valid));

    assert_prio_outside_long_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_idx == IDX_PRIO && mode_e != MODE_LONG)
        |=> (fault_valid && fault_cause == FLT_UD));

    assert_cpl_gp_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && mode_e != MODE_REAL && req_cpl != 2'd0 &&
         (req_idx == IDX_OPMODE || req_idx == IDX_FADDR || req_idx == IDX_TBASE ||
          req_idx == IDX_EXTEN || (req_idx == IDX_PRIO && mode_e == MODE_LONG)))
        |=> (fault_valid && fault_cause == FLT_GP));

    assert_paging_needs_prot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_idx == IDX_OPMODE && req_wdata[31] && !req_wdata[0])
        |=> (fault_valid && $stable(paging_en) && $stable(prot_en)));

    assert_fault_keeps_faddr_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && cause != FLT_NONE) |=> $stable(faddr_q) && $stable(tbase_q));

    assert_task_switch_sets_R13: assert property (@(posedge clk) disable iff (!rst_n)
        task_switch |=> task_sw);

    assert_nm_on_fp_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_valid && fp_issue && task_sw) |=> (fault_valid && fault_cause == FLT_NM));
endmodule

// File: tb/sysctl_regfile_tb.sv
// Scoreboard bench: driver tasks push expected results, a monitor pops
// and compares them at every response or fault pulse.
module sysctl_regfile_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [3:0]  req_idx = '0;
    logic [63:0] req_wdata = '0;
    logic [1:0]  req_cpl = '0, req_mode = '0;
    logic        task_switch = 1'b0, fp_issue = 1'b0;
    logic        rsp_valid, fault_valid;
    logic [63:0] rsp_rdata;
    logic [1:0]  fault_cause;
    logic        prot_en, paging_en, wr_protect, cache_dis, task_sw;
    logic [3:0]  tpr;

    typedef struct {
        logic        is_fault;
        logic [1:0]  cause;
        logic [63:0] data;
        string       req;
    } exp_t;

    exp_t q[$];
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   done  = 0;

    always #5 clk = ~clk;

    sysctl_regfile u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_idx(req_idx), .req_wdata(req_wdata), .req_cpl(req_cpl), .req_mode(req_mode),
        .task_switch(task_switch), .fp_issue(fp_issue), .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata), .fault_valid(fault_valid), .fault_cause(fault_cause),
        .prot_en(prot_en), .paging_en(paging_en), .wr_protect(wr_protect),
        .cache_dis(cache_dis), .task_sw(task_sw), .tpr(tpr)
    );

    // Monitor: compare each pulse against the oldest expectation.
    always @(negedge clk) begin
        if (rst_n && (rsp_valid || fault_valid)) begin
            n_cmp++;
            if (q.size() == 0) begin
                n_bad++;
                $display("FAIL R2: unexpected pulse rsp=%0b fault=%0b cause=%0d, expected none",
                         rsp_valid, fault_valid, fault_cause);
            end else begin
                exp_t e;
                e = q.pop_front();
                if (fault_valid !== e.is_fault || rsp_valid === e.is_fault ||
                    (e.is_fault && fault_cause !== e.cause) ||
                    (!e.is_fault && rsp_rdata !== e.data)) begin
                    n_bad++;
                    $display("FAIL %s: got fault=%0b cause=%0d data=%h, expected fault=%0b cause=%0d data=%h",
                             e.req, fault_valid, fault_cause, rsp_rdata,
                             e.is_fault, e.cause, e.data);
                end
            end
        end
    end

    task automatic do_req(input logic wr, input logic [3:0] idx, input logic [63:0] wd,
                          input logic [1:0] md, input logic [1:0] cpl,
                          input logic flt, input logic [1:0] cs, input logic [63:0] ed,
                          input string tag);
        exp_t e;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_idx = idx; req_wdata = wd;
        req_mode = md; req_cpl = cpl;
        e.is_fault = flt; e.cause = cs; e.data = ed; e.req = tag;
        q.push_back(e);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic ok_wr(input logic [3:0] idx, input logic [63:0] wd, input logic [1:0] md, input string tag);
        do_req(1'b1, idx, wd, md, 2'd0, 1'b0, 2'd0, 64'h0, tag);
    endtask

    task automatic ok_rd(input logic [3:0] idx, input logic [1:0] md, input logic [63:0] ed, input string tag);
        do_req(1'b0, idx, 64'h0, md, 2'd0, 1'b0, 2'd0, ed, tag);
    endtask

    task automatic flt_req(input logic wr, input logic [3:0] idx, input logic [63:0] wd,
                           input logic [1:0] md, input logic [1:0] cpl, input logic [1:0] cs, input string tag);
        do_req(wr, idx, wd, md, cpl, 1'b1, cs, 64'h0, tag);
    endtask

    task automatic check(input logic [63:0] act, input logic [63:0] exp, input string tag);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h, expected %h", tag, act, exp);
        end
    endtask

    localparam logic [1:0] RL = 2'd0, PR = 2'd1, CM = 2'd2, LG = 2'd3;
    localparam logic [1:0] GP = 2'd1, UD = 2'd2, NM = 2'd3;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check({59'h0, prot_en, paging_en, wr_protect, cache_dis, task_sw}, 64'h0, "R1 flags");
        check({60'h0, tpr}, 64'h0, "R1 tpr");
        ok_rd(4'd0, RL, 64'h10, "R1 opmode");
        ok_rd(4'd2, LG, 64'h0, "R1 faddr");
        ok_rd(4'd3, LG, 64'h0, "R1 tbase");
        ok_rd(4'd4, LG, 64'h0, "R1 exten");
        // R8/R5: real mode write of all ones, upper half dropped
        ok_wr(4'd0, 64'hFFFF_FFFF_FFFF_FFFF, RL, "R8 write");
        ok_rd(4'd0, RL, 64'hE005_0039, "R8 readback");
        check({59'h0, prot_en, paging_en, wr_protect, cache_dis, task_sw}, 64'h1F, "R14 flags set");
        // R7: paging without protection
        flt_req(1'b1, 4'd0, 64'h8000_0000, RL, 2'd0, GP, "R7 pg no pe");
        ok_rd(4'd0, RL, 64'hE005_0039, "R12 after R7 fault");
        ok_wr(4'd0, 64'h1, RL, "R14 pe only");
        check({59'h0, prot_en, paging_en, wr_protect, cache_dis, task_sw}, 64'h10, "R14 flags pe");
        // R4: privilege in protected vs real
        flt_req(1'b0, 4'd2, 64'h0, PR, 2'd3, GP, "R4 prot cpl3 read");
        flt_req(1'b1, 4'd2, 64'h5, CM, 2'd1, GP, "R4 compat cpl1 write");
        ok_rd(4'd2, PR, 64'h0, "R12 faddr after R4");
        do_req(1'b0, 4'd0, 64'h0, RL, 2'd3, 1'b0, 2'd0, 64'h11, "R4 real ignores cpl");
        // R9/R5: full width faddr
        ok_wr(4'd2, 64'hDEAD_BEEF_1234_5678, LG, "R9 write");
        ok_rd(4'd2, LG, 64'hDEAD_BEEF_1234_5678, "R9 readback");
        ok_rd(4'd2, PR, 64'h1234_5678, "R5 narrow read");
        // R6
        flt_req(1'b1, 4'd0, 64'h1_0000_0001, LG, 2'd0, GP, "R6 opmode upper");
        ok_wr(4'd4, 64'h6F0, LG, "R6 exten write");
        flt_req(1'b1, 4'd4, 64'h8000_0000_0000_06F0, LG, 2'd0, GP, "R6 exten upper");
        ok_rd(4'd4, LG, 64'h6F0, "R12 exten kept");
        ok_wr(4'd4, 64'hFFFF_FFFF_0000_0001, CM, "R5 exten upper ignored");
        ok_rd(4'd4, LG, 64'h1, "R5 exten readback");
        // R10
        ok_wr(4'd3, 64'h0000_00AB_CDEF_5FFF, LG, "R10 write");
        ok_rd(4'd3, LG, 64'h0000_00AB_CDEF_5018, "R10 readback");
        flt_req(1'b1, 4'd3, 64'h0000_2000_0000_0000, LG, 2'd0, GP, "R10 reserved bit");
        ok_rd(4'd3, LG, 64'h0000_00AB_CDEF_5018, "R12 tbase kept");
        ok_wr(4'd3, 64'h1000_0000_0000_1000, LG, "R10 high bits");
        ok_rd(4'd3, LG, 64'h1000_0000_0000_1000, "R10 high readback");
        ok_wr(4'd3, 64'hFFFF_FFFF_FFFF_FFFF, PR, "R10 32-bit write");
        ok_rd(4'd3, LG, 64'h0000_0000_FFFF_F018, "R10 32-bit readback");
        // R11
        flt_req(1'b0, 4'd8, 64'h0, PR, 2'd0, UD, "R11 prio in prot");
        flt_req(1'b1, 4'd8, 64'hB, RL, 2'd0, UD, "R11 prio in real");
        ok_wr(4'd8, 64'hFB, LG, "R11 write");
        ok_rd(4'd8, LG, 64'hB, "R11 readback");
        check({60'h0, tpr}, 64'hB, "R11 tpr");
        flt_req(1'b0, 4'd8, 64'h0, LG, 2'd3, GP, "R4 prio cpl3");
        // R3
        flt_req(1'b0, 4'd1, 64'h0, RL, 2'd0, UD, "R3 index1");
        flt_req(1'b1, 4'd5, 64'h0, LG, 2'd0, UD, "R3 index5");
        flt_req(1'b0, 4'd1, 64'h0, PR, 2'd3, UD, "R4 UD over GP");
        // R13
        @(negedge clk); task_switch = 1'b1;
        @(negedge clk); task_switch = 1'b0;
        check({63'h0, task_sw}, 64'h1, "R13 ts set");
        ok_rd(4'd0, LG, 64'h19, "R13 ts readback");
        begin
            exp_t e;
            @(negedge clk); fp_issue = 1'b1;
            e.is_fault = 1'b1; e.cause = NM; e.data = '0; e.req = "R13 nm";
            q.push_back(e);
            @(negedge clk); fp_issue = 1'b0;
        end
        ok_wr(4'd0, 64'h1, LG, "R13 clear ts");
        check({63'h0, task_sw}, 64'h0, "R13 ts cleared");
        @(negedge clk); fp_issue = 1'b1;
        @(negedge clk); fp_issue = 1'b0;
        repeat (3) @(negedge clk);
        n_cmp++;
        if (q.size() != 0) begin
            n_bad++;
            $display("FAIL R2: %0d pulses missing, expected 0", q.size());
        end
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule